// File: doc/BRIEF.md
# Stop-Mode Wake-Up Stabilization Controller

This block manages a low-power stop state for a small microcontroller core. A one-cycle stop request puts the core to sleep: the oscillator enable drops, the CPU clock enable is withheld, and the analog-to-digital converter is told to halt. A stop request is accepted only if at least one wake source is armed. A source is armed when it is enabled and its request bit is clear, and global interrupts must also be allowed. If no source is armed, the request is refused and flagged, so the core can never enter a stop it cannot leave.

While asleep, a rising request on an armed and still-enabled source restarts the oscillator. The clock itself is not yet trusted at that point. A two-stage down-counter chain then runs on a prescaled version of the raw oscillator ticks. The first stage is preset to all ones and the second to seven. The CPU clock enable returns only when the second stage runs out. The controller then reports which source woke it and goes back to normal running.

Top module: `stopwake_ctrl`

## Requirements
- R1: After reset, cpu_clk_en=1, osc_en=1, adc_halt=0, stop_err=0 and wake_done=0.
- R2: A stop_req in the run state is accepted when gie_dis=0 and some source i has irq_en[i]=1 and irq_req[i]=0. One cycle later, osc_en=0, cpu_clk_en=0 and adc_halt=1.
- R3: A stop_req in the run state that fails the R2 condition is refused. stop_err pulses high for exactly one cycle, starting the cycle after the request, and cpu_clk_en and osc_en stay 1.
- R4: Only a source armed at entry (enabled with its request clear) can wake the block, and only while it is still enabled. Requests from other sources leave osc_en at 0.
- R5: One cycle after a waking request, osc_en=1 while cpu_clk_en stays 0.
- R6: On entry, the first stage is loaded with all ones (255) and the second stage with 7. The second stage steps once for each first-stage wrap from 0. As a result, cpu_clk_en returns after exactly 2048×D raw osc_tick pulses, where D is 1, 2, 4 or 8 for src_sel values 0, 1, 2 and 3.
- R7: src_sel is sampled at stop entry. Changing it later does not change the wait length.
- R8: Wake requests that arrive during the stabilization wait do not restart or shorten the count.
- R9: In the cycle cpu_clk_en returns, wake_done pulses for one cycle. wake_idx then holds the lowest index among the sources that caused the wake.
- R10: adc_halt is 1 from stop entry until cpu_clk_en returns.
- R11: osc_tick pulses received while osc_en=0 are not counted.
- R12: stop_req is ignored while not in the run state: it produces no stop_err and does not change the wait length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | One-cycle request to enter stop |
| irq_req | input | NSRC | Wake-source request bits |
| irq_en | input | NSRC | Wake-source enable bits |
| gie_dis | input | 1 | Global interrupt disable flag |
| src_sel | input | 2 | First-stage source: raw tick divided by 1, 2, 4 or 8 |
| osc_tick | input | 1 | Raw oscillator tick, one per cycle at most |
| osc_enable | output | 1 | Oscillator run enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| adc_halt | output | 1 | Converter halt flag |
| stop_err | output | 1 | Pulse: stop request refused |
| wake_done | output | 1 | Pulse: CPU clock released |
| wake_idx | output | $clog2(NSRC) | Index of the source that woke the block |

## Verification
Every cycle, the bound checker enforces the following. A refused request pulses stop_err while the CPU clock stays on. An accepted one gates the clock and sets the converter halt. The CPU clock is never on while the oscillator is off. The oscillator comes back before the CPU clock does. The release pulse coincides with the CPU clock returning.

Some behaviours can only be shown by the bench scenarios. These are the exact 2048×D tick count for each divider, the lowest-index reporting of the wake source, and the rejection of unarmed or disabled sources. The bench also shows that ticks, selector changes, extra wake requests and stop requests are ignored in the phases where they must not matter.

// File: rtl/swk_pkg.sv
package swk_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_WAIT = 2'd2
  } swk_state_e;
endpackage

// File: rtl/swk_wake_arb.sv
module swk_wake_arb #(
  parameter int NSRC  = 8,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  irq_req,
  input  logic [NSRC-1:0]  irq_en,
  input  logic [NSRC-1:0]  armed,
  input  logic             gie_dis,
  output logic             can_stop,
  output logic             wake_any,
  output logic [IDX_W-1:0] wake_idx
);
  logic [NSRC-1:0] hits;

  assign can_stop = !gie_dis && (|(irq_en & ~irq_req));
  assign hits     = armed & irq_req & irq_en;
  assign wake_any = |hits;

  // lowest index wins: scan downward so the last hit written is the lowest
  always_comb begin
    wake_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (hits[i]) wake_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/swk_prescaler.sv
module swk_prescaler #(
  parameter int SEL_W = 2,
  parameter int DIV_W = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             osc_tick,
  input  logic [SEL_W-1:0] sel,
  output logic             src_tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W:0]   mask_w;
  logic [DIV_W-1:0] mask;

  assign mask_w   = ((DIV_W+1)'(1) << sel) - (DIV_W+1)'(1);
  assign mask     = mask_w[DIV_W-1:0];
  assign src_tick = run && osc_tick && ((cnt_q & mask) == mask);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                 cnt_d = '0;
    else if (run && osc_tick) cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/swk_stab_chain.sv
module swk_stab_chain #(
  parameter int S1_W    = 8,
  parameter int S2_W    = 3,
  parameter int S2_LOAD = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic ovf
);
  localparam logic [S1_W-1:0] S1_INIT = '1;
  localparam logic [S2_W-1:0] S2_INIT = S2_W'(S2_LOAD);

  logic [S1_W-1:0] s1_q, s1_d;
  logic [S2_W-1:0] s2_q, s2_d;
  logic            s1_wrap;

  assign s1_wrap = tick && (s1_q == '0);
  assign ovf     = s1_wrap && (s2_q == '0);

  always_comb begin
    s1_d = s1_q;
    s2_d = s2_q;
    if (load) begin
      s1_d = S1_INIT;
      s2_d = S2_INIT;
    end else if (tick) begin
      s1_d = s1_wrap ? S1_INIT : s1_q - S1_W'(1);
      if (s1_wrap) s2_d = s2_q - S2_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= S1_INIT;
      s2_q <= S2_INIT;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end
endmodule

// File: rtl/stopwake_ctrl.sv
module stopwake_ctrl
  import swk_pkg::*;
#(
  parameter int NSRC    = 8,
  parameter int SEL_W   = 2,
  parameter int S1_W    = 8,
  parameter int S2_W    = 3,
  parameter int S2_LOAD = 7,
  parameter int IDX_W   = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic [NSRC-1:0]  irq_req,
  input  logic [NSRC-1:0]  irq_en,
  input  logic             gie_dis,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             osc_tick,
  output logic             osc_enable,
  output logic             cpu_clk_en,
  output logic             adc_halt,
  output logic             stop_err,
  output logic             wake_done,
  output logic [IDX_W-1:0] wake_idx
);
  logic [1:0]       rsync_q;
  logic             rst_ns;
  swk_state_e       st_q, st_d;
  logic [NSRC-1:0]  armed_q, armed_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             err_q, err_d, done_q, done_d;
  logic             entry, can_stop, wake_any, src_tick, ovf;
  logic [IDX_W-1:0] arb_idx;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  swk_wake_arb #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
    .irq_req(irq_req), .irq_en(irq_en), .armed(armed_q), .gie_dis(gie_dis),
    .can_stop(can_stop), .wake_any(wake_any), .wake_idx(arb_idx)
  );

  swk_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_ns), .clr(entry), .run(st_q == ST_WAIT),
    .osc_tick(osc_tick), .sel(sel_q), .src_tick(src_tick)
  );

  swk_stab_chain #(.S1_W(S1_W), .S2_W(S2_W), .S2_LOAD(S2_LOAD)) u_chain (
    .clk(clk), .rst_n(rst_ns), .load(entry), .tick(src_tick), .ovf(ovf)
  );

  always_comb begin
    st_d    = st_q;
    armed_d = armed_q;
    sel_d   = sel_q;
    idx_d   = idx_q;
    err_d   = 1'b0;
    done_d  = 1'b0;
    entry   = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (stop_req) begin
          if (can_stop) begin
            entry   = 1'b1;
            st_d    = ST_STOP;
            armed_d = irq_en & ~irq_req;
            sel_d   = src_sel;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (wake_any) begin
          st_d  = ST_WAIT;
          idx_d = arb_idx;
        end
      end
      ST_WAIT: begin
        if (ovf) begin
          st_d   = ST_RUN;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q    <= ST_RUN;
      armed_q <= '0;
      sel_q   <= '0;
      idx_q   <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      armed_q <= armed_d;
      sel_q   <= sel_d;
      idx_q   <= idx_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end

  assign osc_enable = (st_q != ST_STOP);
  assign cpu_clk_en = (st_q == ST_RUN);
  assign adc_halt   = (st_q != ST_RUN);
  assign stop_err   = err_q;
  assign wake_done  = done_q;
  assign wake_idx   = idx_q;
endmodule

// File: rtl/swk_checker.sv
module swk_checker #(
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stop_req,
  input logic [NSRC-1:0] irq_req,
  input logic [NSRC-1:0] irq_en,
  input logic            gie_dis,
  input logic            osc_enable,
  input logic            cpu_clk_en,
  input logic            adc_halt,
  input logic            stop_err,
  input logic            wake_done
);
  logic eligible;
  assign eligible = !gie_dis && (|(irq_en & ~irq_req));

  p_accept_gates_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req && cpu_clk_en && eligible |=> !osc_enable && !cpu_clk_en && adc_halt);

  p_osc_off_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_enable) |-> $past(stop_req));

  p_refuse_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req && cpu_clk_en && !eligible |=> stop_err && cpu_clk_en && osc_enable);

  p_err_only_in_run_r12: assert property (@(posedge clk) disable iff (!rst_n)
    stop_err |-> cpu_clk_en && $past(cpu_clk_en));

  p_osc_before_cpu_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_enable) |-> !cpu_clk_en);

  p_halt_while_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_enable |-> !cpu_clk_en && adc_halt);

  p_release_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> wake_done);

  p_done_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |-> cpu_clk_en && !$past(cpu_clk_en) && !adc_halt);
endmodule

bind stopwake_ctrl swk_checker #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_ns), .stop_req(stop_req), .irq_req(irq_req),
  .irq_en(irq_en), .gie_dis(gie_dis), .osc_enable(osc_enable),
  .cpu_clk_en(cpu_clk_en), .adc_halt(adc_halt), .stop_err(stop_err),
  .wake_done(wake_done)
);

// File: tb/stopwake_ctrl_test.sv
`timescale 1ns/1ps
module stopwake_ctrl_test;
  localparam int NSRC = 8;
  localparam int BASE = 2048;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_req = 1'b0;
  logic [7:0] irq_req = '0;
  logic [7:0] irq_en = '0;
  logic       gie_dis = 1'b0;
  logic [1:0] src_sel = '0;
  logic       osc_tick = 1'b0;
  logic       osc_enable, cpu_clk_en, adc_halt, stop_err, wake_done;
  logic [2:0] wake_idx;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  stopwake_ctrl #(.NSRC(NSRC)) uut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .irq_req(irq_req),
    .irq_en(irq_en), .gie_dis(gie_dis), .src_sel(src_sel), .osc_tick(osc_tick),
    .osc_enable(osc_enable), .cpu_clk_en(cpu_clk_en), .adc_halt(adc_halt),
    .stop_err(stop_err), .wake_done(wake_done), .wake_idx(wake_idx)
  );

  // {src_sel[2], irq_en[8], wake request[8], expected wake_idx[3]}
  localparam logic [20:0] VECS [4] = '{
    {2'd0, 8'h01, 8'h01, 3'd0},
    {2'd1, 8'hF0, 8'hA0, 3'd5},
    {2'd2, 8'h81, 8'h80, 3'd7},
    {2'd3, 8'h3C, 8'h18, 3'd3}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic enter_stop(input logic [1:0] sel, input logic [7:0] en, input logic [7:0] req);
    @(negedge clk);
    src_sel = sel; irq_en = en; irq_req = req; stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    chk("R2 osc_enable low after entry", osc_enable, 0);
    chk("R2 cpu clock gated after entry", cpu_clk_en, 0);
    chk("R10 adc_halt set after entry", adc_halt, 1);
  endtask

  task automatic wake(input logic [7:0] req);
    irq_req = req;
    @(negedge clk);
    chk("R5 osc_enable back after wake", osc_enable, 1);
    chk("R5 cpu clock still gated", cpu_clk_en, 0);
  endtask

  // drives one osc_tick per cycle and counts ticks until the CPU clock returns
  task automatic wait_release(input int exp_ticks, input int exp_idx, input bit disturb);
    int n = 0;
    while (!cpu_clk_en && n < exp_ticks + 64) begin
      osc_tick = 1'b1;
      if (disturb && n == 700) begin
        irq_req = 8'hFF; src_sel = 2'd0; stop_req = 1'b1;
      end
      if (disturb && n == 701) stop_req = 1'b0;
      @(negedge clk);
      if (stop_err) chk("R12 no stop_err during wait", 1, 0);
      if (!cpu_clk_en) chk("R10 adc_halt held during wait", adc_halt, 1);
      n++;
    end
    osc_tick = 1'b0;
    stop_req = 1'b0;
    chk("R6 stabilization tick count", n, exp_ticks);
    chk("R9 wake_done pulse at release", wake_done, 1);
    chk("R9 wake_idx", wake_idx, exp_idx);
    irq_req = '0;
    @(negedge clk);
    chk("R9 wake_done is one cycle", wake_done, 0);
    chk("R10 adc_halt cleared after release", adc_halt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 cpu_clk_en reset", cpu_clk_en, 1);
    chk("R1 osc_enable reset", osc_enable, 1);
    chk("R1 adc_halt reset", adc_halt, 0);
    chk("R1 stop_err reset", stop_err, 0);
    chk("R1 wake_done reset", wake_done, 0);

    // table walk: divider settings and wake-source priority (R6, R9)
    for (int v = 0; v < 4; v++) begin
      enter_stop(VECS[v][20:19], VECS[v][18:11], 8'h00);
      wake(VECS[v][10:3]);
      wait_release(BASE << VECS[v][20:19], int'(VECS[v][2:0]), 1'b0);
    end

    // R3: global disable refuses stop
    @(negedge clk);
    irq_en = 8'h01; irq_req = 8'h00; gie_dis = 1'b1; stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    chk("R3 stop_err on global disable", stop_err, 1);
    chk("R3 cpu clock stays on", cpu_clk_en, 1);
    chk("R3 osc stays on", osc_enable, 1);
    @(negedge clk);
    chk("R3 stop_err one cycle", stop_err, 0);
    gie_dis = 1'b0;

    // R3: every enabled source already pending, nothing armed
    irq_en = 8'h06; irq_req = 8'h06; stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    chk("R3 stop_err with no armed source", stop_err, 1);
    chk("R3 cpu clock stays on, no armed", cpu_clk_en, 1);

    // R4 + R11: unarmed requests and ticks while asleep do nothing
    enter_stop(2'd0, 8'h03, 8'h02);
    irq_req = 8'h06; irq_en = 8'h03; osc_tick = 1'b1;
    repeat (20) @(negedge clk);
    osc_tick = 1'b0;
    chk("R4 unarmed request ignored", osc_enable, 0);
    irq_en = 8'h02; irq_req = 8'h07;
    repeat (3) @(negedge clk);
    chk("R4 disabled armed source ignored", osc_enable, 0);
    irq_en = 8'h03;
    wake(8'h07);
    wait_release(BASE, 0, 1'b0);   // R11 full count despite earlier ticks

    // R7, R8, R12: selector change, extra wakes, stop_req mid-wait
    enter_stop(2'd2, 8'h10, 8'h00);
    wake(8'h10);
    wait_release(BASE * 4, 4, 1'b1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule